// File: doc/BRIEF.md
# Character-Clock Horizontal Timing Generator

This block produces the per-scanline timing of a character-based CRT controller. Each character clock advances a horizontal character counter and a display memory address. From four programmable values it derives three things: a horizontal display enable, a horizontal sync pulse of programmable length, and the point at which a line ends and the counter wraps. At that wrap, the memory address is reloaded with a row-start address that the vertical logic supplies.

The vertical counters use two outputs of this block. The first is a one-cycle strobe raised as horizontal sync ends. The second is the latched address of the last displayed character on the line, from which the next row start can be formed. The timing values sit in a small register file. Software reaches it through a select register and a data register, which share a single write-data bus.

Top module: `hz_timing`

## Requirements
- R1: On every character clock where the counter does not equal the line-total value, the counter and `mem_addr` each increase by one.
- R2: On a clock where the counter equals the line-total value, the counter returns to zero and `mem_addr` takes the value on `row_start`.
- R3: `hde` is high exactly while the counter is less than the display-count value. It is combinational from the counter and the register.
- R4: When sync is low and the counter equals the sync-position value, `hsync` rises on the next clock. A position match that occurs while sync is already high is ignored.
- R5: Once raised, `hsync` stays high for exactly N clocks, where N is bits [3:0] of the sync-width value. Bits [7:4] have no effect.
- R6: A width nibble of zero gives a sync pulse of 16 clocks.
- R7: `hsync_end` is high for exactly one clock: the first clock after `hsync` falls.
- R8: On every clock where `hde` is high, `last_disp_addr` captures `mem_addr` at the next edge. At other times it holds its value.
- R9: A pulse on `sel_we` loads `wdata[3:0]` into the select register. A pulse on `data_we` writes `wdata` to the register at the current select index: 0 is line total, 1 is display count, 2 is sync position, 3 is sync width. A data write while the select register holds 4 to 15 changes nothing.
- R10: While `rst_n` is low, the counter, `mem_addr`, `last_disp_addr`, all four registers and the select register are zero. `hsync`, `hsync_end` and `hde` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low reset |
| sel_we | input | 1 | Load register select from wdata[3:0] |
| data_we | input | 1 | Write wdata to the selected register |
| wdata | input | 8 | Register write data |
| row_start | input | 14 | Row-start address from the vertical logic |
| mem_addr | output | 14 | Current horizontal memory address |
| hde | output | 1 | Horizontal display enable |
| hsync | output | 1 | Horizontal sync |
| hsync_end | output | 1 | One-clock strobe after sync ends |
| last_disp_addr | output | 14 | Address of the last displayed character |

## Verification
Most results are due one edge after their cause. `mem_addr`, `hsync`, `hsync_end` and `last_disp_addr` all reflect the inputs and state sampled at the previous rising edge. `hde` changes in the same cycle as the counter, since it is combinational. A data write alters behaviour from the clock after the write edge onward. The bench therefore drives inputs and advances its reference model once per rising edge. It compares every output at the following falling edge, so each expected value lines up with the single register stage that produced it.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int HZ_NUM_REGS = 4;
   typedef enum logic [1:0] {
      HZ_IDX_TOTAL = 2'd0,
      HZ_IDX_DISP  = 2'd1,
      HZ_IDX_SPOS  = 2'd2,
      HZ_IDX_SWID  = 2'd3
   } hz_idx_e;
   localparam int HZ_NIB_W = 4;
   localparam int HZ_SCNT_W = HZ_NIB_W + 1;
endpackage

// File: rtl/hz_regs.sv
module hz_regs #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] htotal,
   output logic [DATA_W-1:0] hdisp,
   output logic [DATA_W-1:0] hspos,
   output logic [DATA_W-1:0] hswid
);
   import hz_pkg::*;

   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] regs_q [HZ_NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_we) sel_q <= wdata[SEL_W-1:0];
   end

   for (genvar i = 0; i < HZ_NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[i] <= '0;
         else if (data_we && (sel_q == SEL_W'(i)))
            regs_q[i] <= wdata;
      end
   end

   assign htotal = regs_q[HZ_IDX_TOTAL];
   assign hdisp  = regs_q[HZ_IDX_DISP];
   assign hspos  = regs_q[HZ_IDX_SPOS];
   assign hswid  = regs_q[HZ_IDX_SWID];
endmodule

// File: rtl/hz_line_cnt.sv
module hz_line_cnt #(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  htotal,
   input  logic [CNT_W-1:0]  hdisp,
   input  logic [ADDR_W-1:0] row_start,
   output logic [CNT_W-1:0]  hc,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              hde,
   output logic [ADDR_W-1:0] last_disp_addr
);
   logic line_wrap;

   assign line_wrap = (hc == htotal);
   assign hde       = (hc < hdisp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc       <= '0;
         mem_addr <= '0;
      end else if (line_wrap) begin
         hc       <= '0;
         mem_addr <= row_start;
      end else begin
         hc       <= hc + 1'b1;
         mem_addr <= mem_addr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_disp_addr <= '0;
      else if (hde) last_disp_addr <= mem_addr;
   end
endmodule

// File: rtl/hz_sync.sv
module hz_sync #(
   parameter int CNT_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        hc,
   input  logic [CNT_W-1:0]        hspos,
   input  logic [hz_pkg::HZ_NIB_W-1:0] width_nib,
   output logic                    hsync,
   output logic                    hsync_end
);
   import hz_pkg::*;

   logic [HZ_SCNT_W-1:0] scnt_q;
   logic [HZ_SCNT_W-1:0] width_eff;
   logic                 last_beat;

   assign width_eff = (width_nib == '0) ? HZ_SCNT_W'(16) : {1'b0, width_nib};
   assign last_beat = hsync && ((scnt_q + 1'b1) == width_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync     <= 1'b0;
         scnt_q    <= '0;
         hsync_end <= 1'b0;
      end else begin
         hsync_end <= last_beat;
         if (hsync) begin
            scnt_q <= scnt_q + 1'b1;
            if (last_beat) hsync <= 1'b0;
         end else if (hc == hspos) begin
            hsync  <= 1'b1;
            scnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/hz_timing.sv
module hz_timing #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 14,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] row_start,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              hde,
   output logic              hsync,
   output logic              hsync_end,
   output logic [ADDR_W-1:0] last_disp_addr
);
   import hz_pkg::*;

   localparam int CNT_W = DATA_W;

   if (DATA_W < HZ_NIB_W) begin : g_bad_data
      $error("hz_timing: DATA_W must hold a sync width nibble");
   end
   if (SEL_W < 2 || SEL_W > DATA_W) begin : g_bad_sel
      $error("hz_timing: SEL_W must be between 2 and DATA_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("hz_timing: ADDR_W must be positive");
   end

   logic [CNT_W-1:0] htotal_w, hdisp_w, hspos_w, hswid_w, hc_w;

   hz_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
      .wdata(wdata), .htotal(htotal_w), .hdisp(hdisp_w),
      .hspos(hspos_w), .hswid(hswid_w)
   );

   hz_line_cnt #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .htotal(htotal_w), .hdisp(hdisp_w),
      .row_start(row_start), .hc(hc_w), .mem_addr(mem_addr),
      .hde(hde), .last_disp_addr(last_disp_addr)
   );

   hz_sync #(.CNT_W(CNT_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .hc(hc_w), .hspos(hspos_w),
      .width_nib(hswid_w[HZ_NIB_W-1:0]),
      .hsync(hsync), .hsync_end(hsync_end)
   );
endmodule

// File: rtl/hz_timing_chk.sv
module hz_timing_chk #(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  hc,
   input logic [CNT_W-1:0]  htotal,
   input logic [ADDR_W-1:0] row_start,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              hde,
   input logic              hsync,
   input logic              hsync_end,
   input logic [ADDR_W-1:0] last_disp_addr
);
   logic       armed_q;
   logic [4:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         run_q   <= '0;
      end else begin
         armed_q <= 1'b1;
         if (!hsync)              run_q <= '0;
         else if (run_q != 5'd31) run_q <= run_q + 1'b1;
      end
   end

   // R1
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && ($past(hc) != $past(htotal))) |-> (mem_addr == $past(mem_addr) + 1'b1));
   // R2
   line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && ($past(hc) == $past(htotal))) |-> (hc == '0 && mem_addr == $past(row_start)));
   // R5
   sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 5'd16);
   // R7
   end_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $fell(hsync)) |-> hsync_end);
   // R7
   end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_end |=> !hsync_end);
   // R8
   last_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(hde)) |-> (last_disp_addr == $past(mem_addr)));
endmodule

bind hz_timing hz_timing_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hc(hc_w), .htotal(htotal_w),
   .row_start(row_start), .mem_addr(mem_addr), .hde(hde),
   .hsync(hsync), .hsync_end(hsync_end), .last_disp_addr(last_disp_addr)
);

// File: tb/hz_timing_test.sv
`timescale 1ns/1ps
module hz_timing_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_we = 1'b0, data_we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [13:0] row_start = '0;
   logic [13:0] mem_addr, last_disp_addr;
   logic        hde, hsync, hsync_end;

   int vectors = 0, fails = 0;
   bit done = 0;

   // model state
   logic [7:0]  m_reg [4];
   logic [3:0]  m_sel;
   logic [7:0]  m_hc;
   logic [13:0] m_ma, m_last;
   logic        m_hs, m_end;
   logic [4:0]  m_sc;
   int run_len, last_run;

   always #4 clk = ~clk;

   hz_timing uut (
      .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
      .wdata(wdata), .row_start(row_start), .mem_addr(mem_addr),
      .hde(hde), .hsync(hsync), .hsync_end(hsync_end),
      .last_disp_addr(last_disp_addr)
   );

   function automatic logic m_hde();
      return m_hc < m_reg[1];
   endfunction

   function automatic logic [4:0] m_width();
      return (m_reg[3][3:0] == 4'd0) ? 5'd16 : {1'b0, m_reg[3][3:0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      m_sel = '0; m_hc = '0; m_ma = '0; m_last = '0;
      m_hs = 0; m_end = 0; m_sc = '0;
   endtask

   task automatic model_step();
      logic [7:0]  n_hc;
      logic [13:0] n_ma, n_last;
      logic        n_hs, n_end;
      logic [4:0]  n_sc;
      if (m_hc == m_reg[0]) begin n_hc = '0; n_ma = row_start; end
      else begin n_hc = m_hc + 1; n_ma = m_ma + 1; end
      n_last = m_hde() ? m_ma : m_last;
      n_hs = m_hs; n_sc = m_sc; n_end = 0;
      if (m_hs) begin
         n_sc = m_sc + 1;
         if (m_sc + 5'd1 == m_width()) begin n_hs = 0; n_end = 1; end
      end else if (m_hc == m_reg[2]) begin
         n_hs = 1; n_sc = '0;
      end
      if (data_we && m_sel < 4) m_reg[m_sel[1:0]] = wdata;
      if (sel_we) m_sel = wdata[3:0];
      m_hc = n_hc; m_ma = n_ma; m_last = n_last;
      m_hs = n_hs; m_sc = n_sc; m_end = n_end;
   endtask

   task automatic compare_all();
      check("R1/R2 mem_addr", 32'(mem_addr), 32'(m_ma));
      check("R3 hde", 32'(hde), 32'(m_hde()));
      check("R4/R5 hsync", 32'(hsync), 32'(m_hs));
      check("R7 hsync_end", 32'(hsync_end), 32'(m_end));
      check("R8 last_disp_addr", 32'(last_disp_addr), 32'(m_last));
      if (hsync) run_len++;
      else if (run_len > 0) begin last_run = run_len; run_len = 0; end
   endtask

   task automatic cyc(input logic sw, input logic dw, input logic [7:0] wd, input logic [13:0] rs);
      sel_we = sw; data_we = dw; wdata = wd; row_start = rs;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic [3:0] idx, input logic [7:0] val);
      cyc(1, 0, {4'd0, idx}, $urandom);
      cyc(0, 1, val, $urandom);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, '0, $urandom);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      model_reset();
      run_len = 0; last_run = 0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 mem_addr", 32'(mem_addr), 0);
      check("R10 hde", 32'(hde), 0);
      check("R10 hsync", 32'(hsync), 0);
      check("R10 hsync_end", 32'(hsync_end), 0);
      check("R10 last_disp_addr", 32'(last_disp_addr), 0);
      rst_n = 1'b1;
      run(20);

      // R9 register programming
      wr(0, 8'd40); wr(1, 8'd20); wr(2, 8'd24); wr(3, 8'h30);
      run(130);
      // R6 zero nibble gives 16
      check("R6 sync length", last_run, 16);
      wr(3, 8'hF5);
      run(130);
      // R5 width from low nibble only
      check("R5 sync length", last_run, 5);
      begin
         int f0 = fails;
         wr(4'd9, 8'h02);
         run(100);
         // R9 write with out-of-range select leaves timing unchanged
         check("R9 ignored select", fails - f0, 0);
         check("R9 sync length kept", last_run, 5);
      end
      // R4 sync position beyond line total: no sync ever
      wr(2, 8'd60);
      run(100);
      check("R4 no sync when position unreachable", 32'(run_len), 0);

      for (int i = 0; i < 6000; i++) begin
         int r = $urandom_range(0, 99);
         if (r < 2)
            cyc(1, 0, 8'($urandom_range(0, 5)), $urandom);
         else if (r < 4)
            cyc(0, 1, (m_sel == 0) ? 8'($urandom_range(6, 70)) : 8'($urandom), $urandom);
         else
            cyc(0, 0, '0, $urandom);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule